// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block arbitrates five hardware interrupt sources for a small processor core. It combines a global interrupt enable and three per-source mask bits with a fixed priority ladder. At an instruction boundary it picks the winning source and returns a 16-bit service vector, a 3-bit source code and a one-cycle acknowledge. The core pushes the return state and jumps to the vector; that work is outside this block.

The highest level is a non-maskable request. Below it are one edge-triggered source and two level-sensitive sources, each with its own mask bit and a fixed vector. The lowest level is an external request whose vector comes from a 3-bit restart number supplied with it. Accepting any interrupt clears the global enable. A service routine can therefore raise the mask on its own level and below, re-enable interrupts, and be nested only by higher levels. The enable, disable, mask-write and mask-read operations arrive as single-cycle strobes from the core.

Top module: `irq_prio_ctrl`

## Requirements
- R1: When several sources qualify in the same boundary cycle, the winner is the first in this order: nmi, edge source, high level source, low level source, external source.
- R2: A pending nmi is acknowledged at any boundary whatever the global enable and mask bits. It returns vector 0x0024 and source code 4.
- R3: The edge source, high level source and low level source return vectors 0x003C, 0x0034 and 0x002C, with source codes 3, 2 and 1.
- R4: Mask bit 2 blocks the edge source, bit 1 the high level source and bit 0 the low level source; a bit value of 1 blocks. A mask write loads all three bits from mask_wdata_i, effective from the next cycle. While mask_re_i is high, mask_rdata_o equals {global enable, mask[2:0]}; otherwise it is 0.
- R5: While the global enable is clear, only the nmi can be acknowledged.
- R6: Any acknowledge clears the global enable from the next cycle.
- R7: The external source returns vector restart_num_i × 8 (0x0000 to 0x0038) and source code 0.
- R8: After reset the global enable is clear, all three mask bits are 1 and both edge latches are empty. vec_o is 0x0000 in every cycle without an acknowledge.
- R9: Acknowledge is only produced while boundary_i is high. It is combinational in that same cycle.
- R10: A rising edge on nmi_i or edge_irq_i is latched from the next cycle, whatever the enable and mask state. The latch holds until that source is acknowledged. The level sources are not latched.
- R11: After an ei_i strobe, the global enable is set at the edge that ends the next boundary cycle. That boundary cycle therefore still blocks maskable sources.
- R12: di_i clears the global enable and any pending ei_i from the next cycle. It takes precedence over ei_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| nmi_i | input | 1 | Non-maskable request, edge-captured |
| edge_irq_i | input | 1 | Maskable request, edge-captured |
| lvl_hi_i | input | 1 | Maskable level request, higher |
| lvl_lo_i | input | 1 | Maskable level request, lower |
| ext_irq_i | input | 1 | External level request |
| restart_num_i | input | 3 | Restart number for the external vector |
| boundary_i | input | 1 | Instruction boundary strobe |
| ei_i | input | 1 | Enable-interrupts strobe |
| di_i | input | 1 | Disable-interrupts strobe |
| mask_we_i | input | 1 | Mask write strobe |
| mask_wdata_i | input | 3 | Mask write data |
| mask_re_i | input | 1 | Mask read strobe |
| mask_rdata_o | output | 4 | {enable, mask} while reading, else 0 |
| ack_o | output | 1 | Acknowledge pulse |
| src_o | output | 3 | Winning source code |
| vec_o | output | 16 | Service vector |

## Verification
Acknowledge, vector, source code and read-back data are combinational, so they are due in the same cycle as the boundary or read strobe. The bench samples them at the falling edge after driving inputs just past the rising edge. Edge captures, mask writes, enable and disable take effect one rising edge later. The enable strobe also waits for one further boundary. The bench reference model advances its state only at the rising edge, from inputs held stable across it. Each result is therefore compared in exactly the cycle it becomes due.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int VEC_W = 16;
  localparam int NUM_MASK = 3;

  typedef enum logic [2:0] {
    SRC_EXT  = 3'd0,
    SRC_LO   = 3'd1,
    SRC_HI   = 3'd2,
    SRC_EDGE = 3'd3,
    SRC_NMI  = 3'd4
  } irq_src_e;

  localparam int MB_LO   = 0;
  localparam int MB_HI   = 1;
  localparam int MB_EDGE = 2;

  localparam logic [VEC_W-1:0] VEC_NMI  = 16'h0024;
  localparam logic [VEC_W-1:0] VEC_LO   = 16'h002C;
  localparam logic [VEC_W-1:0] VEC_HI   = 16'h0034;
  localparam logic [VEC_W-1:0] VEC_EDGE = 16'h003C;
endpackage

// File: rtl/irq_edge_latch.sv
module irq_edge_latch #(
  parameter int N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] req_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);
  logic [N-1:0] prev_q;

  for (genvar g = 0; g < N; g++) begin : g_lat
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        prev_q[g] <= 1'b0;
        pend_o[g] <= 1'b0;
      end else begin
        prev_q[g] <= req_i[g];
        // new edge wins over a same-cycle clear
        if (req_i[g] && !prev_q[g]) pend_o[g] <= 1'b1;
        else if (clr_i[g])          pend_o[g] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/irq_enable_ctrl.sv
module irq_enable_ctrl #(
  parameter int MASK_W = irq_pkg::NUM_MASK
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ei_i,
  input  logic              di_i,
  input  logic              ack_i,
  input  logic              boundary_i,
  input  logic              mask_we_i,
  input  logic [MASK_W-1:0] mask_wdata_i,
  output logic              ie_o,
  output logic [MASK_W-1:0] mask_o
);
  logic arm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ie_o  <= 1'b0;
      arm_q <= 1'b0;
    end else if (di_i || ack_i) begin
      ie_o  <= 1'b0;
      arm_q <= 1'b0;
    end else begin
      if (boundary_i && arm_q) ie_o <= 1'b1;
      if (ei_i)            arm_q <= 1'b1;
      else if (boundary_i) arm_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        mask_o <= '1;
    else if (mask_we_i) mask_o <= mask_wdata_i;
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_pkg::*;
#(
  parameter int RSTN_W = 3,
  parameter int STRIDE = 3
) (
  input  logic                boundary_i,
  input  logic                ie_i,
  input  logic [NUM_MASK-1:0] mask_i,
  input  logic                nmi_pend_i,
  input  logic                edge_pend_i,
  input  logic                lvl_hi_i,
  input  logic                lvl_lo_i,
  input  logic                ext_i,
  input  logic [RSTN_W-1:0]   ext_num_i,
  output logic                ack_o,
  output irq_src_e            src_o,
  output logic [VEC_W-1:0]    vec_o
);
  localparam int PAD = VEC_W - RSTN_W - STRIDE;

  always_comb begin
    ack_o = 1'b0;
    src_o = SRC_EXT;
    vec_o = '0;
    if (boundary_i) begin
      if (nmi_pend_i) begin
        ack_o = 1'b1; src_o = SRC_NMI; vec_o = VEC_NMI;
      end else if (ie_i) begin
        if (edge_pend_i && !mask_i[MB_EDGE]) begin
          ack_o = 1'b1; src_o = SRC_EDGE; vec_o = VEC_EDGE;
        end else if (lvl_hi_i && !mask_i[MB_HI]) begin
          ack_o = 1'b1; src_o = SRC_HI; vec_o = VEC_HI;
        end else if (lvl_lo_i && !mask_i[MB_LO]) begin
          ack_o = 1'b1; src_o = SRC_LO; vec_o = VEC_LO;
        end else if (ext_i) begin
          ack_o = 1'b1; src_o = SRC_EXT;
          vec_o = {{PAD{1'b0}}, ext_num_i, {STRIDE{1'b0}}};
        end
      end
    end
  end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_pkg::*;
#(
  parameter int RSTN_W = 3,
  parameter int STRIDE = 3,
  localparam int RD_W = NUM_MASK + 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                nmi_i,
  input  logic                edge_irq_i,
  input  logic                lvl_hi_i,
  input  logic                lvl_lo_i,
  input  logic                ext_irq_i,
  input  logic [RSTN_W-1:0]   restart_num_i,
  input  logic                boundary_i,
  input  logic                ei_i,
  input  logic                di_i,
  input  logic                mask_we_i,
  input  logic [NUM_MASK-1:0] mask_wdata_i,
  input  logic                mask_re_i,
  output logic [RD_W-1:0]     mask_rdata_o,
  output logic                ack_o,
  output logic [2:0]          src_o,
  output logic [VEC_W-1:0]    vec_o
);
  logic                ie_q;
  logic [NUM_MASK-1:0] mask_q;
  logic [1:0]          pend_q;   // [1] nmi, [0] edge source
  logic [1:0]          clr;
  irq_src_e            src;

  assign clr[1] = ack_o && (src == SRC_NMI);
  assign clr[0] = ack_o && (src == SRC_EDGE);

  irq_edge_latch #(.N(2)) u_lat (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  ({nmi_i, edge_irq_i}),
    .clr_i  (clr),
    .pend_o (pend_q)
  );

  irq_enable_ctrl #(.MASK_W(NUM_MASK)) u_en (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .ei_i         (ei_i),
    .di_i         (di_i),
    .ack_i        (ack_o),
    .boundary_i   (boundary_i),
    .mask_we_i    (mask_we_i),
    .mask_wdata_i (mask_wdata_i),
    .ie_o         (ie_q),
    .mask_o       (mask_q)
  );

  irq_arbiter #(.RSTN_W(RSTN_W), .STRIDE(STRIDE)) u_arb (
    .boundary_i  (boundary_i),
    .ie_i        (ie_q),
    .mask_i      (mask_q),
    .nmi_pend_i  (pend_q[1]),
    .edge_pend_i (pend_q[0]),
    .lvl_hi_i    (lvl_hi_i),
    .lvl_lo_i    (lvl_lo_i),
    .ext_i       (ext_irq_i),
    .ext_num_i   (restart_num_i),
    .ack_o       (ack_o),
    .src_o       (src),
    .vec_o       (vec_o)
  );

  assign src_o        = src;
  assign mask_rdata_o = mask_re_i ? {ie_q, mask_q} : '0;
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        boundary_i,
  input logic        di_i,
  input logic        ack_o,
  input logic [2:0]  src_o,
  input logic [15:0] vec_o,
  input logic        ie_q,
  input logic [2:0]  mask_q,
  input logic        nmi_pend
);
  AST_ACK_AT_BOUNDARY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> boundary_i); // R9
  AST_ACK_CLEARS_IE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ie_q); // R6
  AST_NMI_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_o && src_o != 3'd4) |-> !nmi_pend); // R1
  AST_GATED_BY_IE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_o && src_o != 3'd4) |-> ie_q); // R5
  AST_LO_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_o && src_o == 3'd1) |-> !mask_q[0]); // R4
  AST_EXT_VEC_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_o && src_o == 3'd0) |-> (vec_o[2:0] == 3'd0 && vec_o[15:6] == 10'd0)); // R7
  AST_DI_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    di_i |=> !ie_q); // R12
  AST_IDLE_VEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ack_o |-> vec_o == 16'h0000); // R8
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .boundary_i (boundary_i),
  .di_i       (di_i),
  .ack_o      (ack_o),
  .src_o      (src_o),
  .vec_o      (vec_o),
  .ie_q       (ie_q),
  .mask_q     (mask_q),
  .nmi_pend   (pend_q[1])
);

// File: tb/sim_irq_prio_ctrl.sv
`timescale 1ns/1ps
module sim_irq_prio_ctrl;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic nmi = 0, edg = 0, lhi = 0, llo = 0, ext = 0, bnd = 0, ei = 0, di = 0, mwe = 0, mre = 0;
  logic [2:0] num = 0, mwd = 0;
  logic [3:0] rdata;
  logic ack;
  logic [2:0] src;
  logic [15:0] vec;
  int n_chk = 0, n_fail = 0;

  // reference state
  logic m_ie = 0, m_arm = 0, m_pn = 0, m_pe = 0, m_prev_n = 0, m_prev_e = 0;
  logic [2:0] m_mask = 3'b111;

  always #5 clk = ~clk;

  irq_prio_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_ni), .nmi_i(nmi), .edge_irq_i(edg), .lvl_hi_i(lhi),
    .lvl_lo_i(llo), .ext_irq_i(ext), .restart_num_i(num), .boundary_i(bnd),
    .ei_i(ei), .di_i(di), .mask_we_i(mwe), .mask_wdata_i(mwd), .mask_re_i(mre),
    .mask_rdata_o(rdata), .ack_o(ack), .src_o(src), .vec_o(vec)
  );

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic logic [19:0] ref_arb();
    logic [2:0] s;
    logic [15:0] v;
    if (!bnd) return 20'd0;
    if (m_pn) return {1'b1, 3'd4, 16'h0024};
    if (!m_ie) return 20'd0;
    if (m_pe && !m_mask[2]) return {1'b1, 3'd3, 16'h003C};
    if (lhi && !m_mask[1]) return {1'b1, 3'd2, 16'h0034};
    if (llo && !m_mask[0]) return {1'b1, 3'd1, 16'h002C};
    if (ext) begin s = 3'd0; v = {10'd0, num, 3'd0}; return {1'b1, s, v}; end
    return 20'd0;
  endfunction

  task automatic cyc();
    logic [19:0] e;
    logic n_ie, n_arm, n_pn, n_pe;
    logic [2:0] n_mask;
    @(negedge clk);
    e = ref_arb();
    chk("R1 R9 ack", {15'd0, ack}, {15'd0, e[19]});
    if (e[19]) chk("R1 R2 R3 R7 src", {13'd0, src}, {13'd0, e[18:16]});
    chk("R3 R7 R8 vec", vec, e[15:0]);
    chk("R4 rdata", {12'd0, rdata}, mre ? {12'd0, m_ie, m_mask} : 16'd0);
    n_pn = (nmi && !m_prev_n) ? 1'b1 : (e[19] && e[18:16] == 3'd4) ? 1'b0 : m_pn;
    n_pe = (edg && !m_prev_e) ? 1'b1 : (e[19] && e[18:16] == 3'd3) ? 1'b0 : m_pe;
    n_ie = m_ie; n_arm = m_arm;
    if (di || e[19]) begin n_ie = 0; n_arm = 0; end
    else begin
      if (bnd && m_arm) n_ie = 1;
      if (ei) n_arm = 1; else if (bnd) n_arm = 0;
    end
    n_mask = mwe ? mwd : m_mask;
    @(posedge clk);
    m_prev_n = nmi; m_prev_e = edg;
    m_pn = n_pn; m_pe = n_pe; m_ie = n_ie; m_arm = n_arm; m_mask = n_mask;
    #1;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    void'($urandom(32'd1234));
    mre = 1; bnd = 1; lhi = 1; llo = 1; ext = 1;
    @(negedge clk);
    chk("R8 reset ack", {15'd0, ack}, 16'd0);
    chk("R8 reset vec", vec, 16'h0000);
    chk("R8 reset mask", {12'd0, rdata}, 16'h0007);
    @(posedge clk); #1 rst_ni = 1;
    // A: maskable requests blocked with enable clear
    #2 chk("R5 no ack ie low", {15'd0, ack}, 16'd0);
    cyc();
    // B: nmi edge, no boundary
    bnd = 0; nmi = 1; cyc();
    #2 chk("R9 no ack off boundary", {15'd0, ack}, 16'd0);
    cyc();
    bnd = 1;
    #2 chk("R2 nmi vec", vec, 16'h0024);
    chk("R2 nmi src", {13'd0, src}, 16'd4);
    cyc();
    // D: clear mask, then ei delay
    nmi = 0; bnd = 0; lhi = 0; llo = 0; ext = 0; mwe = 1; mwd = 3'b000; cyc();
    mwe = 0; ei = 1; cyc();
    ei = 0; bnd = 1; ext = 1; num = 3'd7;
    #2 chk("R11 ei not yet active", {15'd0, ack}, 16'd0);
    cyc();
    #2 chk("R7 ext vec", vec, 16'h0038);
    chk("R7 ext src", {13'd0, src}, 16'd0);
    cyc();
    #2 chk("R6 ie cleared by ack", {15'd0, ack}, 16'd0);
    cyc();
    // I: edge captured while disabled
    bnd = 0; ext = 0; ei = 1; edg = 1; cyc();
    ei = 0; bnd = 1; cyc();
    lhi = 1; llo = 1; ext = 1;
    #2 chk("R1 R3 edge wins", vec, 16'h003C);
    chk("R10 edge src", {13'd0, src}, 16'd3);
    cyc();
    bnd = 0; ei = 1; cyc();
    ei = 0; bnd = 1; cyc();
    #2 chk("R10 R1 latch cleared, hi next", vec, 16'h0034);
    cyc();
    // O: mask high level only
    bnd = 0; mwe = 1; mwd = 3'b010; ei = 1; cyc();
    mwe = 0; ei = 0; bnd = 1; cyc();
    #2 chk("R4 masked hi skipped", vec, 16'h002C);
    chk("R3 lo src", {13'd0, src}, 16'd1);
    cyc();
    // R: di cancels enable
    bnd = 0; ei = 1; lhi = 0; llo = 0; ext = 0; cyc();
    ei = 0; bnd = 1; cyc();
    bnd = 0; di = 1; ei = 1; cyc();
    di = 0; ei = 0; bnd = 1; llo = 1;
    #2 chk("R12 di blocks", {15'd0, ack}, 16'd0);
    cyc();
    cyc();
    #2 chk("R12 di cancels pending ei", {15'd0, ack}, 16'd0);
    cyc();
    // random phase
    for (int i = 0; i < 4000; i++) begin
      bnd = ($urandom_range(0, 1) == 0);
      ei  = ($urandom_range(0, 5) == 0);
      di  = ($urandom_range(0, 15) == 0);
      mwe = ($urandom_range(0, 9) == 0);
      mwd = 3'($urandom_range(0, 7));
      mre = ($urandom_range(0, 2) == 0);
      lhi = ($urandom_range(0, 5) == 0);
      llo = ($urandom_range(0, 4) == 0);
      ext = ($urandom_range(0, 3) == 0);
      num = 3'($urandom_range(0, 7));
      if ($urandom_range(0, 7) == 0)  edg = ~edg;
      if ($urandom_range(0, 24) == 0) nmi = ~nmi;
      cyc();
    end
    summary();
  end
endmodule